// File: doc/BRIEF.md
# Edge-Blanked Dead-Time Generator

This block turns one logic-level switching waveform into two gate-drive enables that are never on together. Each time the sampled input changes level, a blanking window opens and holds both enables low for a programmed number of system clocks. The window closes once a counter has seen the new level persist for that many clocks. The counter then copies the new level into a "settled" register, and the enable for the new phase is released. The window is the exclusive-OR of the live sampled level and the settled level. It therefore lasts exactly as long as the two disagree, whatever the input frequency or duty cycle.

Two decodes are offered. In bridge mode the high-side enable follows the input's high phase and the low-side enable follows its low phase. In rectifier mode the roles swap, which gives the polarity a synchronous-rectifier switch needs alongside its primary. A phase no longer than the dead time never turns its enable on. A glitch shorter than the dead time only interrupts the enable that was already on.

Top module: `deadtime_gen`

## Requirements
- R1: While reset is asserted both enables are low, and the dead-time register takes the parameter value RST_DEAD (4 by default).
- R2: `drv_hi` and `drv_lo` are never high in the same cycle.
- R3: When the input has a new level sampled at clock edge k, the enable that was on goes low after edge k+1. The enable for the new level goes high after edge k+N+1, where N is the dead-time register, provided the new level is held for more than N sampled edges.
- R4: The dead time N is any value from 1 to 2^CNT_W-1 (1 to 255 by default). A write of 0 is stored as 1.
- R5: With `dt_we` high at a clock edge, `dt_val` is loaded into the dead-time register. With `dt_we` low, the register holds its value.
- R6: With `rect_mode` = 0, `drv_hi` is the enable for input level 1 and `drv_lo` is the enable for input level 0.
- R7: With `rect_mode` = 1, `drv_hi` is the enable for input level 0 and `drv_lo` is the enable for input level 1.
- R8: An input phase of L ≤ N sampled edges never turns on its own enable. If L < N, the previous enable turns back on after edge k+L+1. If L = N, it turns back on after edge k+2N+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwm_in | input | 1 | Switching waveform to be split |
| dt_we | input | 1 | Load strobe for the dead-time register |
| dt_val | input | CNT_W | Dead time in clocks (0 is stored as 1) |
| rect_mode | input | 1 | 0: bridge decode, 1: rectifier decode |
| drv_hi | output | 1 | High-side (or phase-A) gate enable |
| drv_lo | output | 1 | Low-side (or phase-B) gate enable |

## Verification
Input changes are counted from the edge k that samples them. The old enable falls one edge later, and the new one rises N+1 edges later. For a short phase of L edges, the old enable returns either L+1 or L+N+1 edges later. The bench drives each pulse at a falling edge and, at every following falling edge, compares both enables with those closed-form edge numbers. It sweeps every pulse length from 1 to 2N+2 for several small N, both modes and both idle levels, plus the extreme N=255 around its boundary. No result is taken from a cycle other than the one the formula names.

// File: rtl/dtg_pkg.sv
package dtg_pkg;

   typedef enum logic {
      DRV_BRIDGE = 1'b0,
      DRV_RECT   = 1'b1
   } drv_mode_e;

   localparam int unsigned DTG_MIN_W = 2;
   localparam int unsigned DTG_MAX_W = 16;

endpackage

// File: rtl/dtg_cfg.sv
module dtg_cfg #(
   parameter int unsigned CNT_W    = 8,
   parameter int unsigned RST_DEAD = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [CNT_W-1:0] din,
   output logic [CNT_W-1:0] dead
);
   localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
   localparam logic [CNT_W-1:0] RST_VAL = CNT_W'(RST_DEAD);

   logic [CNT_W-1:0] dead_q;
   logic [CNT_W-1:0] din_fix;

   assign din_fix = (din == '0) ? ONE : din;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dead_q <= RST_VAL;
      end else if (we) begin
         dead_q <= din_fix;
      end
   end

   assign dead = dead_q;

   always_comb begin
      if (rst_n) begin
         p_dead_nonzero_r4: assert (dead_q != '0);
      end
   end

   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(dead_q));

endmodule

// File: rtl/dtg_edge_blank.sv
module dtg_edge_blank #(
   parameter int unsigned CNT_W       = 8,
   parameter int unsigned SYNC_STAGES = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             src,
   input  logic [CNT_W-1:0] dead,
   output logic             lvl,
   output logic             blank
);
   logic [SYNC_STAGES-1:0] samp_q;
   logic                   settled_q;
   logic [CNT_W-1:0]       run_q;
   logic [CNT_W:0]         run_nx;
   logic                   run_done;

   generate
      if (SYNC_STAGES == 1) begin : g_one_stage
         always_ff @(posedge clk) begin
            if (!rst_n) samp_q <= '0;
            else        samp_q <= src;
         end
      end else begin : g_chain
         always_ff @(posedge clk) begin
            if (!rst_n) samp_q <= '0;
            else        samp_q <= {samp_q[SYNC_STAGES-2:0], src};
         end
      end
   endgenerate

   assign lvl      = samp_q[SYNC_STAGES-1];
   assign blank    = lvl ^ settled_q;
   assign run_nx   = {1'b0, run_q} + 1'b1;
   assign run_done = (run_nx >= {1'b0, dead});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         settled_q <= 1'b0;
         run_q     <= '0;
      end else if (!blank) begin
         run_q     <= '0;
      end else if (run_done) begin
         settled_q <= lvl;
         run_q     <= '0;
      end else begin
         run_q     <= run_nx[CNT_W-1:0];
      end
   end

   p_blank_open_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(blank) && (lvl != $past(lvl))) |-> blank);

   p_blank_close_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(blank) && $past(run_done) && (lvl == $past(lvl))) |-> !blank);

endmodule

// File: rtl/dtg_drive.sv
module dtg_drive
   import dtg_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      lvl,
   input  logic      blank,
   input  drv_mode_e mode,
   output logic      hi,
   output logic      lo
);
   logic phase_hi;
   logic hi_q;
   logic lo_q;

   assign phase_hi = lvl ^ (mode == DRV_RECT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_q <= 1'b0;
         lo_q <= 1'b0;
      end else begin
         hi_q <= !blank && phase_hi;
         lo_q <= !blank && !phase_hi;
      end
   end

   assign hi = hi_q;
   assign lo = lo_q;

   p_no_overlap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(hi_q && lo_q));

   p_blank_gates_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(blank) |-> (!hi_q && !lo_q));

endmodule

// File: rtl/deadtime_gen.sv
module deadtime_gen
   import dtg_pkg::*;
#(
   parameter int unsigned CNT_W       = 8,
   parameter int unsigned RST_DEAD    = 4,
   parameter int unsigned SYNC_STAGES = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pwm_in,
   input  logic             dt_we,
   input  logic [CNT_W-1:0] dt_val,
   input  logic             rect_mode,
   output logic             drv_hi,
   output logic             drv_lo
);
   localparam int unsigned DEAD_MAX = (1 << CNT_W) - 1;

   generate
      if (CNT_W < DTG_MIN_W || CNT_W > DTG_MAX_W) begin : g_bad_width
         $error("deadtime_gen: CNT_W out of range");
      end
      if (RST_DEAD < 1 || RST_DEAD > DEAD_MAX) begin : g_bad_reset
         $error("deadtime_gen: RST_DEAD out of range");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("deadtime_gen: SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] dead;
   logic             lvl;
   logic             blank;
   drv_mode_e        mode;

   assign mode = rect_mode ? DRV_RECT : DRV_BRIDGE;

   dtg_cfg #(
      .CNT_W    (CNT_W),
      .RST_DEAD (RST_DEAD)
   ) u_cfg (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (dt_we),
      .din   (dt_val),
      .dead  (dead)
   );

   dtg_edge_blank #(
      .CNT_W       (CNT_W),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_blank (
      .clk   (clk),
      .rst_n (rst_n),
      .src   (pwm_in),
      .dead  (dead),
      .lvl   (lvl),
      .blank (blank)
   );

   dtg_drive u_drive (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (lvl),
      .blank (blank),
      .mode  (mode),
      .hi    (drv_hi),
      .lo    (drv_lo)
   );

   p_hi_phase_r7: assert property (@(posedge clk) disable iff (!rst_n)
      drv_hi |-> ($past(lvl) != $past(rect_mode)));

   p_lo_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
      drv_lo |-> ($past(lvl) == $past(rect_mode)));

endmodule

// File: tb/deadtime_gen_test.sv
module deadtime_gen_test;
   localparam int CW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pwm_in = 1'b0;
   logic          dt_we = 1'b0;
   logic [CW-1:0] dt_val = '0;
   logic          rect_mode = 1'b0;
   logic          drv_hi;
   logic          drv_lo;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   always #5 clk = ~clk;

   deadtime_gen #(.CNT_W(CW), .RST_DEAD(4), .SYNC_STAGES(1)) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .pwm_in    (pwm_in),
      .dt_we     (dt_we),
      .dt_val    (dt_val),
      .rect_mode (rect_mode),
      .drv_hi    (drv_hi),
      .drv_lo    (drv_lo)
   );

   task automatic chk(input string req, input logic act, input logic exp, input int e);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s step %0d: actual %b expected %b", req, e, act, exp);
      end
   endtask

   // Pulse from idle level b to ~b lasting len sampled edges, dead time n.
   task automatic run_pulse(input int n, input int len, input logic b, input logic sr,
                            input logic do_wr, input int wr_val);
      logic q;
      logic p_is_hi;
      logic exp_p;
      logic exp_b;
      string rq;
      q = ~b;
      p_is_hi = q ^ sr;
      @(negedge clk);
      rect_mode = sr;
      pwm_in    = b;
      if (do_wr) begin
         dt_we  = 1'b1;
         dt_val = CW'(wr_val);
      end
      @(negedge clk);
      dt_we = 1'b0;
      repeat (n + 4) @(negedge clk);
      pwm_in = q;
      for (int s = 1; s <= len + 2 * n + 4; s++) begin
         @(negedge clk);
         begin
            int e;
            e = s - 1;
            exp_p = (len > n) && (e >= n + 1) && (e <= len);
            exp_b = (e <= 0) || ((len < n) ? (e >= len + 1) : (e >= len + n + 1));
            if (len <= n) rq = sr ? "R8 R7 R4" : "R8 R6 R4";
            else          rq = sr ? "R3 R7 R4" : "R3 R6 R4";
            chk(rq, p_is_hi ? drv_hi : drv_lo, exp_p, e);
            chk(rq, p_is_hi ? drv_lo : drv_hi, exp_b, e);
            chk("R2", drv_hi & drv_lo, 1'b0, e);
         end
         pwm_in = (s < len) ? q : b;
      end
   endtask

   initial begin
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
         end
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1", drv_hi, 1'b0, 0);
      chk("R1", drv_lo, 1'b0, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1", drv_lo, 1'b1, 0);
      chk("R1", drv_hi, 1'b0, 0);

      // R1 / R5: reset dead time of 4 used without any write
      run_pulse(4, 7, 1'b0, 1'b0, 1'b0, 0);
      run_pulse(4, 3, 1'b0, 1'b0, 1'b0, 0);

      // R4: a write of 0 behaves as 1
      run_pulse(1, 1, 1'b0, 1'b0, 1'b1, 0);
      run_pulse(1, 3, 1'b0, 1'b1, 1'b0, 0);

      // R3 R6 R7 R8: sweep small dead times, lengths, modes, idle levels
      foreach (dead_set[i]) begin
         for (int m = 0; m < 2; m++) begin
            for (int bl = 0; bl < 2; bl++) begin
               for (int len = 1; len <= 2 * dead_set[i] + 2; len++) begin
                  run_pulse(dead_set[i], len, bl[0], m[0], 1'b1, dead_set[i]);
               end
            end
         end
      end

      // R4: largest dead time around its boundary
      run_pulse(255, 254, 1'b0, 1'b0, 1'b1, 255);
      run_pulse(255, 255, 1'b1, 1'b1, 1'b0, 0);
      run_pulse(255, 256, 1'b0, 1'b0, 1'b0, 0);

      // R5: register holds 255 without a write, then reloads a small value
      run_pulse(2, 5, 1'b0, 1'b0, 1'b1, 2);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   int dead_set [4] = '{1, 2, 3, 7};

endmodule